// File: doc/BRIEF.md
# Floating-Point Conditional Flow Sequencer

This block works out where execution goes next for the floating-point conditional instructions: conditional branch, conditional set, decrement-and-branch, and conditional trap. A decoder pulses `start` and supplies five things with it:

- the instruction kind;
- the opcode size fields;
- the address of the instruction;
- up to two displacement words;
- the current value of the loop counter register.

A separate condition evaluator supplies the predicate. One clock later the block raises `done` for a single cycle. It presents the next program counter, a taken flag, and strobes for the three possible side effects: a counter write-back, a set byte, and a trap request.

The block does not read memory, decode effective addresses or build exception frames. The surrounding core fetches the words, stores the results and stacks the trap frame. Every start also copies the instruction address into a floating-point instruction-address register, so a later exception can name the failing instruction.

When the upstream condition logic reports an unordered-branch exception, the instruction is abandoned. The PC stays at the instruction address and no side effect is produced.

Top module: `fpu_cc_seq`

## Requirements
- R1: After reset, these outputs are 0: `done`, `taken`, `cnt_we`, `set_we`, `trap_req`, `next_pc`, `trap_vec`, `trap_pc`, `iar`.
- R2: The outputs change only in response to a start pulse.
  - `done` is high for exactly the one cycle that follows a cycle with `start` high, and is low otherwise.
  - `cnt_we`, `set_we` and `trap_req` are high only while `done` is high.
  - All results are valid in that `done` cycle.
- R3: Conditional branch (`kind`=0) with `long_disp`=0:
  - if the predicate is true, `taken`=1 and `next_pc` = `orig_pc`+2+sign-extended `disp_lo`;
  - if it is false, `taken`=0 and `next_pc` = `orig_pc`+4.
- R4: Conditional branch with `long_disp`=1 uses the 32-bit displacement {`disp_hi`,`disp_lo`}, with the high word first:
  - if the predicate is true, `next_pc` = `orig_pc`+2+displacement;
  - if it is false, `next_pc` = `orig_pc`+6.
- R5: Conditional set (`kind`=1) behaves as follows:
  - `set_we`=1;
  - `set_byte` is 0xFF when the predicate is true and 0x00 when it is false;
  - `taken`=0 and `next_pc` = `orig_pc`+4.
- R6: Decrement-and-branch (`kind`=2) with a true predicate falls through: `taken`=0, `cnt_we`=0, and `next_pc` = `orig_pc`+6.
- R7: Decrement-and-branch with a false predicate behaves as follows:
  - it writes back `cnt_in` with its low 16 bits decremented by one, keeping the upper bits; `cnt_we`=1;
  - it branches to `orig_pc`+2+sign-extended `disp_lo` unless the new low half is 0xFFFF;
  - when the new low half is 0xFFFF, `taken`=0 and `next_pc` = `orig_pc`+6.
- R8: Conditional trap (`kind`=3) takes its operand size from `trap_mode`:
  - 3'b100 means 0 bytes, 3'b010 means 2 bytes, and 3'b011 means 4 bytes;
  - any other code counts as 0 bytes;
  - `next_pc` = `orig_pc`+2+size, and `taken`=0.
- R9: A conditional trap with a true predicate raises `trap_req` with `trap_vec`=7 and `trap_pc`=`orig_pc`. With a false predicate, `trap_req` stays 0.
- R10: On every start pulse, of any kind and with or without an exception, `iar` takes `orig_pc` and holds it until the next start.
- R11: When `bsun_exc` is high with `start`, the instruction is abandoned:
  - `next_pc` = `orig_pc` and `taken`=0;
  - `cnt_we`, `set_we` and `trap_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction; inputs sampled this cycle |
| kind | input | 2 | 0 branch, 1 set, 2 decrement-and-branch, 3 trap |
| long_disp | input | 1 | Branch displacement size: 0 16-bit, 1 32-bit |
| trap_mode | input | 3 | Trap operand size code |
| orig_pc | input | AW | Address of the instruction |
| disp_hi | input | 16 | First displacement word (high half of a 32-bit displacement) |
| disp_lo | input | 16 | 16-bit displacement, or low half of a 32-bit displacement |
| cnt_in | input | CW | Current loop counter register value |
| cond_true | input | 1 | Predicate from the condition evaluator |
| bsun_exc | input | 1 | Unordered-branch exception raised upstream |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | AW | Next program counter |
| taken | output | 1 | A branch was taken |
| cnt_we | output | 1 | Write `cnt_out` back to the counter register |
| cnt_out | output | CW | Decremented counter value |
| set_we | output | 1 | Store `set_byte` |
| set_byte | output | 8 | 0xFF or 0x00 result of the set instruction |
| trap_req | output | 1 | Request a trap exception |
| trap_vec | output | 8 | Trap vector number |
| trap_pc | output | AW | Instruction address reported with the trap |
| iar | output | AW | Floating-point instruction-address register |

## Verification
The assertions check the timing rules on every cycle:
- the done pulse that follows each start;
- side-effect strobes that appear only with `done`;
- the copy of the instruction address;
- preservation of the upper counter bits;
- the trap vector and trap address;
- the suppression of every side effect under an unordered-branch exception.

Only the bench's sweeps show that the target arithmetic is right. These sweeps cover:
- the sign extension of short and long displacements;
- the 0xFFFF loop exit;
- each trap size code.

// File: rtl/fpu_cc_seq.sv
module fpu_cc_seq #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter logic [7:0] TRAP_VEC = 8'd7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic          long_disp,
  input  logic [2:0]    trap_mode,
  input  logic [AW-1:0] orig_pc,
  input  logic [15:0]   disp_hi,
  input  logic [15:0]   disp_lo,
  input  logic [CW-1:0] cnt_in,
  input  logic          cond_true,
  input  logic          bsun_exc,
  output logic          done,
  output logic [AW-1:0] next_pc,
  output logic          taken,
  output logic          cnt_we,
  output logic [CW-1:0] cnt_out,
  output logic          set_we,
  output logic [7:0]    set_byte,
  output logic          trap_req,
  output logic [7:0]    trap_vec,
  output logic [AW-1:0] trap_pc,
  output logic [AW-1:0] iar
);
  localparam logic [1:0] K_BR = 2'd0, K_SET = 2'd1, K_DB = 2'd2, K_TRAP = 2'd3;

  logic [AW-1:0] pc2, d_short, d_long, t_size;
  logic [15:0]   dec;
  logic [AW-1:0] n_pc;
  logic          n_taken, n_cwe, n_swe, n_trap;

  assign pc2     = orig_pc + AW'(2);
  assign d_short = AW'($signed(disp_lo));
  assign d_long  = AW'($signed({disp_hi, disp_lo}));
  assign dec     = cnt_in[15:0] - 16'd1;

  always_comb begin
    case (trap_mode)
      3'b010:  t_size = AW'(2);
      3'b011:  t_size = AW'(4);
      default: t_size = '0;
    endcase
  end

  always_comb begin
    n_pc    = orig_pc;
    n_taken = 1'b0;
    n_cwe   = 1'b0;
    n_swe   = 1'b0;
    n_trap  = 1'b0;
    if (!bsun_exc) begin
      case (kind)
        K_BR: begin
          n_taken = cond_true;
          if (cond_true) n_pc = pc2 + (long_disp ? d_long : d_short);
          else           n_pc = pc2 + (long_disp ? AW'(4) : AW'(2));
        end
        K_SET: begin
          n_swe = 1'b1;
          n_pc  = pc2 + AW'(2);
        end
        K_DB: begin
          n_pc = pc2 + AW'(4);
          if (!cond_true) begin
            n_cwe = 1'b1;
            if (dec != 16'hFFFF) begin
              n_taken = 1'b1;
              n_pc    = pc2 + d_short;
            end
          end
        end
        default: begin
          n_pc   = pc2 + t_size;
          n_trap = cond_true;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      next_pc  <= '0;
      taken    <= 1'b0;
      cnt_we   <= 1'b0;
      cnt_out  <= '0;
      set_we   <= 1'b0;
      set_byte <= '0;
      trap_req <= 1'b0;
      trap_vec <= '0;
      trap_pc  <= '0;
      iar      <= '0;
    end else begin
      done     <= start;
      cnt_we   <= start & n_cwe;
      set_we   <= start & n_swe;
      trap_req <= start & n_trap;
      if (start) begin
        iar     <= orig_pc;
        next_pc <= n_pc;
        taken   <= n_taken;
        if (n_cwe) cnt_out  <= {cnt_in[CW-1:16], dec};
        if (n_swe) set_byte <= cond_true ? 8'hFF : 8'h00;
        trap_vec <= n_trap ? TRAP_VEC : 8'h00;
        trap_pc  <= n_trap ? orig_pc : '0;
      end
    end
  end
endmodule

module fpu_cc_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter logic [7:0] TRAP_VEC = 8'd7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    kind,
  input logic [AW-1:0] orig_pc,
  input logic [CW-1:0] cnt_in,
  input logic          cond_true,
  input logic          bsun_exc,
  input logic          done,
  input logic [AW-1:0] next_pc,
  input logic          taken,
  input logic          cnt_we,
  input logic [CW-1:0] cnt_out,
  input logic          set_we,
  input logic          trap_req,
  input logic [7:0]    trap_vec,
  input logic [AW-1:0] trap_pc,
  input logic [AW-1:0] iar
);
  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R2
  done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R2
  strobe_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we | set_we | trap_req) |-> done);
  // R10
  iar_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> iar == $past(orig_pc));
  // R7
  cnt_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && kind == 2'd2 && !cond_true && !bsun_exc) |=>
      (cnt_we && cnt_out[CW-1:16] == $past(cnt_in[CW-1:16])));
  // R9
  trap_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && kind == 2'd3 && cond_true && !bsun_exc) |=>
      (trap_req && trap_vec == TRAP_VEC && trap_pc == $past(orig_pc)));
  // R11
  bsun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bsun_exc) |=>
      (!cnt_we && !set_we && !trap_req && !taken && next_pc == $past(orig_pc)));
endmodule

bind fpu_cc_seq fpu_cc_seq_chk #(.AW(AW), .CW(CW), .TRAP_VEC(TRAP_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .orig_pc(orig_pc),
  .cnt_in(cnt_in), .cond_true(cond_true), .bsun_exc(bsun_exc), .done(done),
  .next_pc(next_pc), .taken(taken), .cnt_we(cnt_we), .cnt_out(cnt_out),
  .set_we(set_we), .trap_req(trap_req), .trap_vec(trap_vec), .trap_pc(trap_pc),
  .iar(iar)
);

// File: tb/sim_fpu_cc_seq.sv
`timescale 1ns/1ps
module sim_fpu_cc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  kind = '0;
  logic        long_disp = 1'b0;
  logic [2:0]  trap_mode = '0;
  logic [31:0] orig_pc = '0;
  logic [15:0] disp_hi = '0, disp_lo = '0;
  logic [31:0] cnt_in = '0;
  logic        cond_true = 1'b0, bsun_exc = 1'b0;
  logic        done, taken, cnt_we, set_we, trap_req;
  logic [31:0] next_pc, cnt_out, trap_pc, iar;
  logic [7:0]  set_byte, trap_vec;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fpu_cc_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .long_disp(long_disp),
    .trap_mode(trap_mode), .orig_pc(orig_pc), .disp_hi(disp_hi), .disp_lo(disp_lo),
    .cnt_in(cnt_in), .cond_true(cond_true), .bsun_exc(bsun_exc), .done(done),
    .next_pc(next_pc), .taken(taken), .cnt_we(cnt_we), .cnt_out(cnt_out),
    .set_we(set_we), .set_byte(set_byte), .trap_req(trap_req), .trap_vec(trap_vec),
    .trap_pc(trap_pc), .iar(iar)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] k, input logic lg, input logic [2:0] tm,
                     input logic [31:0] pc, input logic [31:0] disp32,
                     input logic [31:0] cnt, input logic c, input logic b);
    logic [31:0] e_pc, ds, dl, tsz;
    logic [15:0] nd;
    logic e_tk, e_cwe, e_swe, e_trap;
    string rq;
    ds = {{16{disp32[15]}}, disp32[15:0]};
    dl = disp32;
    nd = cnt[15:0] - 16'd1;
    tsz = (tm == 3'b010) ? 32'd2 : (tm == 3'b011) ? 32'd4 : 32'd0;
    e_tk = 0; e_cwe = 0; e_swe = 0; e_trap = 0; e_pc = pc;
    case (k)
      2'd0: begin
        rq = lg ? "R4" : "R3";
        e_tk = c;
        e_pc = c ? pc + 32'd2 + (lg ? dl : ds) : pc + (lg ? 32'd6 : 32'd4);
      end
      2'd1: begin rq = "R5"; e_swe = 1; e_pc = pc + 32'd4; end
      2'd2: begin
        if (c) begin rq = "R6"; e_pc = pc + 32'd6; end
        else begin
          rq = "R7"; e_cwe = 1;
          e_tk = (nd != 16'hFFFF);
          e_pc = e_tk ? pc + 32'd2 + ds : pc + 32'd6;
        end
      end
      default: begin rq = c ? "R9" : "R8"; e_pc = pc + 32'd2 + tsz; e_trap = c; end
    endcase
    if (b) begin
      rq = "R11"; e_pc = pc; e_tk = 0; e_cwe = 0; e_swe = 0; e_trap = 0;
    end
    @(negedge clk);
    kind = k; long_disp = lg; trap_mode = tm; orig_pc = pc;
    disp_hi = disp32[31:16]; disp_lo = disp32[15:0]; cnt_in = cnt;
    cond_true = c; bsun_exc = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "done", 32'(done), 32'd1);
    chk(rq, "next_pc", next_pc, e_pc);
    chk(rq, "taken", 32'(taken), 32'(e_tk));
    chk(rq, "cnt_we", 32'(cnt_we), 32'(e_cwe));
    chk(rq, "set_we", 32'(set_we), 32'(e_swe));
    chk(rq, "trap_req", 32'(trap_req), 32'(e_trap));
    chk("R10", "iar", iar, pc);
    if (e_cwe) chk("R7", "cnt_out", cnt_out, {cnt[31:16], nd});
    if (e_swe) chk("R5", "set_byte", 32'(set_byte), c ? 32'hFF : 32'h00);
    if (e_trap) begin
      chk("R9", "trap_vec", 32'(trap_vec), 32'd7);
      chk("R9", "trap_pc", trap_pc, pc);
    end
    @(negedge clk);
    chk("R2", "done_drop", 32'(done), 32'd0);
    chk("R2", "strobes_drop", 32'({cnt_we, set_we, trap_req}), 32'd0);
    chk("R10", "iar_hold", iar, pc);
  endtask

  logic [31:0] disps [4];
  logic [31:0] cnts [5];

  initial begin
    disps[0] = 32'h0000_0010; disps[1] = 32'h0000_FFF0;
    disps[2] = 32'h0001_2000; disps[3] = 32'hFFFF_8000;
    cnts[0] = 32'h0000_0000; cnts[1] = 32'h0000_0001; cnts[2] = 32'hABCD_0005;
    cnts[3] = 32'h1234_FFFF; cnts[4] = 32'h5555_8000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", 32'(done), 0);
    chk("R1", "strobes", 32'({taken, cnt_we, set_we, trap_req}), 0);
    chk("R1", "next_pc", next_pc, 0);
    chk("R1", "trap", {24'd0, trap_vec} | trap_pc, 0);
    chk("R1", "iar", iar, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
          for (int di = 0; di < 4; di++) begin
            logic [31:0] pc;
            pc = 32'h0040_1000 + 32'(k * 256 + di * 16 + b * 4 + c * 2);
            if (k == 0) begin
              run(2'(k), 1'b0, 3'b100, pc, disps[di], 32'h0, c[0], b[0]);
              run(2'(k), 1'b1, 3'b100, pc, disps[di], 32'h0, c[0], b[0]);
            end else if (k == 2) begin
              for (int ci = 0; ci < 5; ci++)
                run(2'(k), 1'b0, 3'b100, pc, disps[di], cnts[ci], c[0], b[0]);
            end else if (k == 3) begin
              for (int tm = 0; tm < 8; tm++)
                run(2'(k), 1'b0, 3'(tm), pc, disps[di], 32'h0, c[0], b[0]);
            end else begin
              run(2'(k), 1'b0, 3'b100, pc, disps[di], 32'h0, c[0], b[0]);
            end
          end
    // R6 near wrap with a true predicate: the counter is left untouched
    run(2'd2, 1'b0, 3'b100, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0000_0000, 1'b1, 1'b0);
    // R3 address wraps around the top of the space
    run(2'd0, 1'b0, 3'b100, 32'hFFFF_FFFC, 32'h0000_0010, 32'h0, 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule